// File: doc/BRIEF.md
# Serial Frame Deframer with Sync Hunt

This block takes a serial bit stream whose bit clock runs from a modem and bears no phase relation to the system clock, and cuts it into frames of parameter code words. Each frame is a fixed sequence of words of unequal widths. One slot, the pitch slot at index 0, carries a fixed sync pattern in unvoiced frames. That pattern stands for an out-of-range pitch value, so it never occurs there as real data.

The deframer samples the line on each rising edge of the bit clock after a two-flop synchronizer. It slides a window over the most recent bits and notes where in the frame (modulo the frame length) the pattern shows up. It declares lock only when the pattern appears at one and the same offset in six consecutive frames. At that moment it realigns its bit and word counters. From then on every completed word is presented in parallel with its index, and a frame strobe marks each full parameter set.

Top module: `frame_deframer`

## Requirements
- R1: During and right after reset, `locked`, `word_valid` and `frame_done` are low.
- R2: Exactly one bit is taken per rising edge of `ser_clk`. The bit is the level of `ser_dat` at that edge, seen after a two-stage synchronizer. Words are sent most significant bit first.
- R3: A sync hit is a bit after which the last SYNC_W received bits (oldest first) equal SYNC_PAT. The default is 7 ones. A hit counts only once SYNC_W bits have arrived since reset.
- R4: The hunter keeps each hit's position within the frame, modulo FRAME_LEN (28 bits by default). Lock is declared on the LOCK_FRAMES-th (default 6) consecutive hit at one position, and never earlier. A hit at another position restarts the count at one. A frame with no hit at the kept position clears the count.
- R5: At lock, the counters are loaded so that the next bit is the first bit of the word after the sync slot (word 1 by default).
- R6: Once locked, each completed word gives a one-cycle `word_valid`, with the word right-aligned in `word_data` and its index in `word_idx`. The default widths for indices 0..5 are 7, 5, 5, 4, 4, 3.
- R7: `frame_done` pulses in the same cycle as the valid of the last word (index 5). It fires only for frames whose every word, word 0 included, was delivered after lock. It never fires for the frame in which lock falls.
- R8: Before lock, `word_valid` and `frame_done` stay low.
- R9: Once declared, lock holds until reset, even if later frames carry no pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Modem bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, valid at ser_clk rising edge |
| locked | output | 1 | Frame alignment found |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | DATA_W | Completed word, right-aligned |
| word_idx | output | IDX_W | Position of the word in the frame |
| frame_done | output | 1 | Last word of a complete frame |

## Verification
Two events can land on the same bit strobe. The first is the sixth pattern hit, which declares lock. In that same cycle the counter reload collides with the hunter's window update and with the assembler, which has not yet begun to run. The second is the last word's valid, which coincides with the frame strobe.

The bench provokes the first event by shifting the stream three bits between frames, so the count restarts, and by dropping one pattern between two runs of five. It then judges the lock level right after each sync word, along with the exact words that follow. It judges the second event by counting frame strobes. For the frame in which lock occurs the count must be zero, and for each later frame it must be exactly one, always paired with word index 5.

// File: rtl/frame_deframer_pkg.sv
package frame_deframer_pkg;

  // Width of word idx, taken from a table of 4-bit fields (index 0 at LSB).
  function automatic int field_width(logic [63:0] tbl, int idx);
    return int'(tbl[idx*4 +: 4]);
  endfunction

  // Total bits of the first n fields of the table.
  function automatic int frame_sum(logic [63:0] tbl, int n);
    int s;
    s = 0;
    for (int i = 0; i < 16; i++)
      if (i < n) s += int'(tbl[i*4 +: 4]);
    return s;
  endfunction

  // Bits needed to hold values 0..v (at least one).
  function automatic int bits_for(int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/fd_bitclk_sync.sv
module fd_bitclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic bit_stb,
  output logic bit_val
);
  logic [STAGES:0]   clk_pipe;
  logic [STAGES-1:0] dat_pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-1:0], ser_clk};
      dat_pipe <= {dat_pipe[STAGES-2:0], ser_dat};
    end
  end

  // rising edge of the synchronized bit clock
  assign bit_stb = clk_pipe[STAGES-1] & ~clk_pipe[STAGES];
  assign bit_val = dat_pipe[STAGES-1];
endmodule

// File: rtl/fd_sync_hunter.sv
module fd_sync_hunter
  import frame_deframer_pkg::*;
#(
  parameter int                SYNC_W      = 7,
  parameter logic [SYNC_W-1:0] SYNC_PAT    = '1,
  parameter int                FRAME_LEN   = 28,
  parameter int                LOCK_FRAMES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  output logic sync_hit,
  output logic lock_now,
  output logic locked
);
  localparam int POS_W  = bits_for(FRAME_LEN - 1);
  localparam int CNT_W  = bits_for(LOCK_FRAMES);
  localparam int FILL_W = bits_for(SYNC_W);

  logic [SYNC_W-1:0] win;
  logic [SYNC_W-1:0] win_nx;
  logic [FILL_W-1:0] fill;
  logic [POS_W-1:0]  pos, anchor, pos_nx;
  logic [CNT_W-1:0]  run;
  logic              filled_nx, at_anchor;

  assign win_nx    = (win << 1) | SYNC_W'(bit_val);
  assign filled_nx = int'(fill) >= SYNC_W - 1;
  assign sync_hit  = bit_stb && filled_nx && (win_nx == SYNC_PAT);
  assign at_anchor = (run != '0) && (pos == anchor);
  assign pos_nx    = (int'(pos) == FRAME_LEN - 1) ? '0 : pos + 1'b1;
  assign lock_now  = sync_hit && !locked &&
                     ((LOCK_FRAMES == 1) ||
                      (at_anchor && int'(run) == LOCK_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win    <= '0;
      fill   <= '0;
      pos    <= '0;
      anchor <= '0;
      run    <= '0;
      locked <= 1'b0;
    end else if (bit_stb) begin
      win <= win_nx;
      if (!filled_nx) fill <= fill + 1'b1;
      if (lock_now) locked <= 1'b1;
      if (!locked) begin
        pos <= pos_nx;
        if (sync_hit) begin
          if (at_anchor) begin
            run <= run + 1'b1;
          end else begin
            run    <= CNT_W'(1);
            anchor <= pos;
          end
        end else if (at_anchor) begin
          run <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fd_word_assembler.sv
module fd_word_assembler
  import frame_deframer_pkg::*;
#(
  parameter int          NW       = 6,
  parameter logic [63:0] WIDTHS   = 64'h0000_0000_0034_4557,
  parameter int          DATA_W   = 8,
  parameter int          SYNC_IDX = 0,
  parameter int          IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              lock_now,
  input  logic              locked,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic [IDX_W-1:0]  word_idx,
  output logic              frame_done
);
  localparam int BC_W = bits_for(DATA_W);
  localparam logic [IDX_W-1:0] RELOAD_IDX =
    IDX_W'((SYNC_IDX == NW - 1) ? 0 : SYNC_IDX + 1);

  logic [BC_W-1:0]   bit_ctr;
  logic [IDX_W-1:0]  word_ctr, word_ctr_nx;
  logic [DATA_W-1:0] acc, acc_base, acc_nx;
  logic              seen_first, word_end, last_word;
  int                cur_w;

  assign cur_w       = field_width(WIDTHS, int'(word_ctr));
  assign acc_base    = (bit_ctr == '0) ? '0 : acc;
  assign acc_nx      = (acc_base << 1) | DATA_W'(bit_val);
  assign word_end    = bit_stb && locked && (int'(bit_ctr) == cur_w - 1);
  assign last_word   = int'(word_ctr) == NW - 1;
  assign word_ctr_nx = last_word ? '0 : word_ctr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_ctr    <= '0;
      word_ctr   <= '0;
      acc        <= '0;
      seen_first <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_idx   <= '0;
      frame_done <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      frame_done <= 1'b0;
      if (lock_now) begin
        bit_ctr    <= '0;
        word_ctr   <= RELOAD_IDX;
        seen_first <= 1'b0;
      end else if (bit_stb && locked) begin
        acc <= acc_nx;
        if (word_end) begin
          word_valid <= 1'b1;
          word_data  <= acc_nx;
          word_idx   <= word_ctr;
          bit_ctr    <= '0;
          word_ctr   <= word_ctr_nx;
          if (word_ctr == '0) seen_first <= 1'b1;
          if (last_word && (seen_first || word_ctr == '0)) frame_done <= 1'b1;
        end else begin
          bit_ctr <= bit_ctr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_deframer.sv
module frame_deframer
  import frame_deframer_pkg::*;
#(
  parameter int                NW          = 6,
  parameter logic [63:0]       WORD_WIDTHS = 64'h0000_0000_0034_4557,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_IDX    = 0,
  parameter int                SYNC_W      = 7,
  parameter logic [SYNC_W-1:0] SYNC_PAT    = 7'h7F,
  parameter int                LOCK_FRAMES = 6,
  parameter int                SYNC_STAGES = 2,
  localparam int               IDX_W       = bits_for(NW - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              locked,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic [IDX_W-1:0]  word_idx,
  output logic              frame_done
);
  localparam int FRAME_LEN = frame_sum(WORD_WIDTHS, NW);

  logic bit_stb, bit_val, sync_hit, lock_now;

  fd_bitclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  fd_sync_hunter #(
    .SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT),
    .FRAME_LEN(FRAME_LEN), .LOCK_FRAMES(LOCK_FRAMES)
  ) u_hunt (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .sync_hit(sync_hit), .lock_now(lock_now), .locked(locked)
  );

  fd_word_assembler #(
    .NW(NW), .WIDTHS(WORD_WIDTHS), .DATA_W(DATA_W),
    .SYNC_IDX(SYNC_IDX), .IDX_W(IDX_W)
  ) u_asm (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .lock_now(lock_now), .locked(locked),
    .word_valid(word_valid), .word_data(word_data), .word_idx(word_idx),
    .frame_done(frame_done)
  );
endmodule

// File: rtl/frame_deframer_chk.sv
module frame_deframer_chk #(
  parameter int NW    = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_stb,
  input logic             sync_hit,
  input logic             lock_now,
  input logic             locked,
  input logic             word_valid,
  input logic [IDX_W-1:0] word_idx,
  input logic             frame_done
);
  assert_one_strobe_per_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  assert_hit_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |-> bit_stb);

  assert_lock_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_now |-> sync_hit);

  assert_lock_from_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(lock_now));

  assert_word_follows_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_stb));

  assert_idx_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (int'(word_idx) < NW));

  assert_done_with_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (word_valid && int'(word_idx) == NW - 1));

  assert_quiet_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!word_valid && !frame_done));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

bind frame_deframer frame_deframer_chk #(.NW(NW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .sync_hit(sync_hit),
  .lock_now(lock_now), .locked(locked), .word_valid(word_valid),
  .word_idx(word_idx), .frame_done(frame_done)
);

// File: tb/sim_frame_deframer.sv
`timescale 1ns/1ps
module sim_frame_deframer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       locked, word_valid, frame_done;
  logic [7:0] word_data;
  logic [2:0] word_idx;

  int n_chk = 0;
  int n_fail = 0;
  int words_seen = 0;
  int frames_seen = 0;
  bit exp_live = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_w [6];

  localparam int BW [6] = '{7, 5, 5, 4, 4, 3};
  localparam logic [20:0] FRAMES [14] = '{
    21'h1A5C3, 21'h0F0F0, 21'h13579, 21'h1FFFF, 21'h0ACE1, 21'h15555,
    21'h0BEEF, 21'h1C0DE, 21'h02468, 21'h1ABCD, 21'h07777, 21'h10F1E,
    21'h0D00D, 21'h1E3E3};

  always #2.5 clk = ~clk;

  frame_deframer u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .locked(locked), .word_valid(word_valid), .word_data(word_data),
    .word_idx(word_idx), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // word k of a frame: fields packed word1 first, msb and lsb forced low
  function automatic logic [7:0] field_of(input logic [20:0] d, input int k);
    int lo;
    logic [7:0] v;
    lo = 0;
    for (int j = 5; j > k; j--) lo += BW[j];
    v = 8'((d >> lo) & ((21'd1 << BW[k]) - 1));
    v[BW[k]-1] = 1'b0;
    v[0] = 1'b0;
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (!exp_live) check(1'b0, "R8 word before lock", int'(word_idx), -1);
      else check(word_data == exp_w[word_idx], "R6 word data", int'(word_data),
                 int'(exp_w[word_idx]));
      words_seen++;
    end
    if (rst_n && frame_done) begin
      check(word_idx == 3'd5, "R7 done on last word", int'(word_idx), 5);
      frames_seen++;
    end
  end

  task automatic send_bit(input logic b);
    ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (6) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [7:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic prep_frame(input logic [20:0] d, input bit with_sync);
    exp_w[0] = with_sync ? 8'h7F : 8'h00;
    for (int k = 1; k < 6; k++) exp_w[k] = field_of(d, k);
  endtask

  task automatic send_body();
    for (int k = 1; k < 6; k++) send_word(exp_w[k], BW[k]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ser_clk = 1'b0;
    ser_dat = 1'b0;
    exp_live = 1'b0;
    repeat (5) @(negedge clk);
    check(locked == 1'b0, "R1 locked at reset", int'(locked), 0);
    check(word_valid == 1'b0, "R1 word_valid at reset", int'(word_valid), 0);
    check(frame_done == 1'b0, "R1 frame_done at reset", int'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int w0;
    int f0;
    do_reset();
    // test 1: table walk, offset shifted after three frames (R3, R4 restart)
    repeat (11) send_bit(1'b0);
    for (int i = 0; i < 14; i++) begin
      if (i == 3) repeat (3) send_bit(1'b0);
      prep_frame(FRAMES[i], 1'b1);
      exp_live = (i >= 8);
      send_word(exp_w[0], BW[0]);
      check(locked == (i >= 8), "R4 lock on sixth same-offset frame",
            int'(locked), int'(i >= 8));
      send_body();
      if (i == 7) check(words_seen == 0, "R8 silent before lock", words_seen, 0);
      if (i == 8) begin
        check(words_seen == 5, "R5 realigned words of lock frame", words_seen, 5);
        check(frames_seen == 0, "R7 no strobe for partial frame", frames_seen, 0);
      end
    end
    check(words_seen == 35, "R2 R6 word count", words_seen, 35);
    check(frames_seen == 5, "R7 frame strobe count", frames_seen, 5);

    // test 2: missing pattern clears the run, lock is sticky
    do_reset();
    check(locked == 1'b0, "R9 lock cleared by reset", int'(locked), 0);
    w0 = words_seen;
    f0 = frames_seen;
    repeat (5) send_bit(1'b0);
    for (int i = 0; i < 12; i++) begin
      prep_frame(FRAMES[(i + 5) % 14], i != 5);
      exp_live = (i == 11);
      send_word(exp_w[0], BW[0]);
      if (i == 10) check(locked == 1'b0, "R4 gap frame cleared run", int'(locked), 0);
      if (i == 11) check(locked == 1'b1, "R4 lock after fresh run of six", int'(locked), 1);
      send_body();
    end
    check(words_seen - w0 == 5, "R5 words after second lock", words_seen - w0, 5);
    prep_frame(FRAMES[2], 1'b0);
    send_word(exp_w[0], BW[0]);
    send_body();
    check(locked == 1'b1, "R9 lock held without pattern", int'(locked), 1);
    check(words_seen - w0 == 11, "R6 full frame after lock", words_seen - w0, 11);
    check(frames_seen - f0 == 1, "R7 one strobe for full frame", frames_seen - f0, 1);
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(negedge clk);
      if (finished) break;
    end
    if (!finished) check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule